// File: doc/BRIEF.md
# EDO DRAM Controller with Byte Lanes

This block is a synchronous controller placed between a simple host request port and an asynchronous 16-bit EDO DRAM. The DRAM array holds 1024 rows of 1024 sixteen-bit words. Row and column addresses share ten address pins. Each byte of the data word has its own column strobe. The host presents word requests with a valid/ready handshake. A request carries a 20-bit word address, a direction, a 2-bit byte enable and write data. Reads return a full word together with a one-cycle valid pulse.

Every DRAM timing limit is a parameter counted in clock cycles. A state machine opens a row, runs column cycles, and closes the row with a RAS precharge. Between two column cycles it holds the strobes high for a precharge interval. While a row is open, later requests to the same row are served as page-mode column cycles without a new row activation. A request to another row, an expiring RAS low-time budget, or a due refresh closes the page first. Refresh uses the CAS-before-RAS order, so the DRAM supplies the refresh row itself. A pending refresh takes priority over host requests.

All DRAM pins leave the block from registers, and their values are computed from the next state. The data bus is split into an output, an output enable and an input, and these are joined at the pad ring.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, RAS, both column strobes, WE and OE are high. The data driver is off, and rd_valid and req_ready are low.
- R2: When RAS falls, the address pins carry the row, which is req_addr[19:10]. When a column strobe falls, they carry the column, which is req_addr[9:0].
- R3: In a write, req_be[0] selects the lower strobe, which covers data bits 7:0. req_be[1] selects the upper strobe, which covers bits 15:8. The strobe of a lane whose enable bit is 0 stays high, so that byte keeps its stored value. A write with req_be = 00 leaves the word unchanged.
- R4: A read lowers both strobes and lowers OE only during its column cycle. It returns the whole stored word on rd_data with rd_valid high for exactly one cycle.
- R5: The data driver is on only during write column cycles. It is never on while OE is low. At least one cycle separates OE going high from the driver turning on, and the driver turning off from OE going low.
- R6: Back-to-back requests to the row that is already open are served without a new row activation.
- R7: A request to a different row while a page is open first raises RAS for a precharge, then opens the new row.
- R8: RAS stays low for at least T_RAS_MIN cycles and high for at least T_RP cycles. A column strobe stays high for at least T_CP cycles between page column cycles.
- R9: A refresh is requested every REF_INTERVAL cycles. It is performed with both strobes low and WE high before RAS falls.
- R10: A pending refresh is served before any new host request, and an open page is closed for it. Under continuous host traffic the refresh rate is kept.
- R11: RAS is never low for more than T_RAS_MAX cycles. An open page left idle is closed before that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in 19:10, column in 9:0 |
| req_be | input | 2 | Byte enables for writes, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-byte column strobe, active low |
| dram_cash_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_o | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_i | input | 16 | Data from the DRAM |

## Verification
The hardest situation to reach is a refresh that comes due while a page is open and host traffic is continuous. In that case the refresh must win over a request that is already waiting. The bench streams a long run of same-row writes without gaps and compares the refresh count seen by its DRAM model with the elapsed cycles. The page time limit is another hard case. The bench lines its stimulus up just after a refresh so that nothing else can close the page, then leaves a page open and idle. Byte-lane effects are seen only through later reads, so every partial write in the table is followed by a read of the same word.

// File: rtl/edo_pkg.sv
package edo_pkg;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 10;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_COL_ACC,
        ST_COL_PRE,
        ST_RAS_PRE,
        ST_REF_CAS,
        ST_REF_RAS
    } state_e;
endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int REF_INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic pending_o
);
    localparam int CW = $clog2(REF_INTERVAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_s;

    tmr_s d, q;

    always_comb begin
        d = q;
        if (ack_i) d.pend = 1'b0;
        if (int'(q.cnt) == REF_INTERVAL - 1) begin
            d.cnt  = '0;
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending_o = q.pend;

    // R9: the sequencer only takes a refresh that is actually due
    a_r9_ack_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> pending_o);
endmodule

// File: rtl/edo_lane_strobes.sv
module edo_lane_strobes #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_nx_i,
    input  logic             ref_nx_i,
    input  logic             wr_nx_i,
    input  logic [LANES-1:0] be_nx_i,
    output logic [LANES-1:0] cas_n_o
);
    logic [LANES-1:0] cas_n_d, cas_n_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            cas_n_d[i] = 1'b1;
            if (ref_nx_i) cas_n_d[i] = 1'b0;
            else if (col_nx_i && (!wr_nx_i || be_nx_i[i])) cas_n_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cas_n_q <= '1;
        else        cas_n_q <= cas_n_d;
    end

    assign cas_n_o = cas_n_q;
endmodule

// File: rtl/edo_seq.sv
module edo_seq
    import edo_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 3,
    parameter int T_CP      = 1,
    parameter int T_RP      = 4,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 1250,
    parameter int T_CSR     = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [LANES-1:0]       req_be,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_ready,
    input  logic                   ref_pend_i,
    output logic                   ref_ack_o,
    input  logic [DATA_W-1:0]      dq_i,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   ras_n,
    output logic                   we_n,
    output logic                   oe_n,
    output logic [AP_W-1:0]        addr,
    output logic [DATA_W-1:0]      dq_o,
    output logic                   dq_oe,
    output logic                   col_nx_o,
    output logic                   ref_nx_o,
    output logic                   wr_nx_o,
    output logic [LANES-1:0]       be_nx_o
);
    localparam int AP_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int M1    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int M2    = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int M3    = (T_RAS_MIN > T_CSR) ? T_RAS_MIN : T_CSR;
    localparam int M12   = (M1 > M2) ? M1 : M2;
    localparam int MAXD  = (M12 > M3) ? M12 : M3;
    localparam int CNT_W = $clog2(MAXD + 1);
    localparam int RC_W  = $clog2(T_RAS_MAX + 1);

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } req_s;

    typedef struct packed {
        state_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [RC_W-1:0]   ras_cnt;
        req_s              req;
        logic              ras_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [AP_W-1:0]   addr;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } seq_s;

    seq_s d, q;
    logic ready_c, ack_c, row_hit, done, may_close, fits;
    int   low_now;

    always_comb begin
        d          = q;
        ready_c    = 1'b0;
        ack_c      = 1'b0;
        d.rd_valid = 1'b0;
        d.cnt      = (q.cnt != '0) ? q.cnt - 1'b1 : q.cnt;
        d.ras_cnt  = q.ras_n ? '0 : q.ras_cnt + 1'b1;
        row_hit    = (req_addr[ROW_W+COL_W-1:COL_W] == q.req.row);
        done       = (q.cnt == '0);
        low_now    = int'(q.ras_cnt) + 1;
        may_close  = (low_now >= T_RAS_MIN);
        fits       = (low_now + T_CAS + T_CP <= T_RAS_MAX);

        case (q.st)
            ST_RAS_PRE: begin
                if (done) d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_pend_i) begin
                    ack_c = 1'b1;
                    d.st  = ST_REF_CAS;
                    d.cnt = CNT_W'(T_CSR - 1);
                end else if (req_valid) begin
                    ready_c     = 1'b1;
                    d.req.wr    = req_write;
                    d.req.row   = req_addr[ROW_W+COL_W-1:COL_W];
                    d.req.col   = req_addr[COL_W-1:0];
                    d.req.be    = req_be;
                    d.req.wdata = req_wdata;
                    d.st        = ST_ROW_OPEN;
                    d.cnt       = CNT_W'(T_RCD - 1);
                end
            end
            ST_ROW_OPEN: begin
                if (done) begin
                    d.st  = ST_COL_ACC;
                    d.cnt = CNT_W'(T_CAS - 1);
                end
            end
            ST_COL_ACC: begin
                if (done) begin
                    if (!q.req.wr) begin
                        d.rd_valid = 1'b1;
                        d.rd_data  = dq_i;
                    end
                    d.st  = ST_COL_PRE;
                    d.cnt = CNT_W'(T_CP - 1);
                end
            end
            ST_COL_PRE: begin
                if (done) begin
                    if (ref_pend_i) begin
                        if (may_close) begin
                            d.st  = ST_RAS_PRE;
                            d.cnt = CNT_W'(T_RP - 1);
                        end
                    end else if (req_valid && row_hit && fits) begin
                        ready_c     = 1'b1;
                        d.req.wr    = req_write;
                        d.req.col   = req_addr[COL_W-1:0];
                        d.req.be    = req_be;
                        d.req.wdata = req_wdata;
                        d.st        = ST_COL_ACC;
                        d.cnt       = CNT_W'(T_CAS - 1);
                    end else if (req_valid || !fits) begin
                        if (may_close) begin
                            d.st  = ST_RAS_PRE;
                            d.cnt = CNT_W'(T_RP - 1);
                        end
                    end
                end
            end
            ST_REF_CAS: begin
                if (done) begin
                    d.st  = ST_REF_RAS;
                    d.cnt = CNT_W'(T_RAS_MIN - 1);
                end
            end
            ST_REF_RAS: begin
                if (done) begin
                    d.st  = ST_RAS_PRE;
                    d.cnt = CNT_W'(T_RP - 1);
                end
            end
            default: d.st = ST_RAS_PRE;
        endcase

        d.ras_n = !(d.st inside {ST_ROW_OPEN, ST_COL_ACC, ST_COL_PRE, ST_REF_RAS});
        d.we_n  = !(d.st == ST_COL_ACC && d.req.wr);
        d.oe_n  = !(d.st == ST_COL_ACC && !d.req.wr);
        d.dq_oe = (d.st == ST_COL_ACC) && d.req.wr;
        if (d.st == ST_ROW_OPEN)      d.addr = AP_W'(d.req.row);
        else if (d.st == ST_COL_ACC)  d.addr = AP_W'(d.req.col);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_RAS_PRE;
            q.cnt   <= CNT_W'(T_RP - 1);
            q.ras_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = ready_c;
    assign ref_ack_o = ack_c;
    assign rd_valid  = q.rd_valid;
    assign rd_data   = q.rd_data;
    assign ras_n     = q.ras_n;
    assign we_n      = q.we_n;
    assign oe_n      = q.oe_n;
    assign addr      = q.addr;
    assign dq_o      = q.req.wdata;
    assign dq_oe     = q.dq_oe;
    assign col_nx_o  = (d.st == ST_COL_ACC);
    assign ref_nx_o  = (d.st == ST_REF_CAS) || (d.st == ST_REF_RAS);
    assign wr_nx_o   = d.req.wr;
    assign be_nx_o   = d.req.be;

    // R10: a due refresh blocks new host requests
    a_r10_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend_i |-> !req_ready);
    // R6: a request taken while RAS is low targets the open row
    a_r6_page_hit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !ras_n) |-> (req_addr[ROW_W+COL_W-1:COL_W] == q.req.row));
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 3,
    parameter int T_CP         = 1,
    parameter int T_RP         = 4,
    parameter int T_RAS_MIN    = 6,
    parameter int T_RAS_MAX    = 1250,
    parameter int T_CSR        = 1,
    parameter int REF_INTERVAL = 1950
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [LANES-1:0]       req_be,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   dram_ras_n,
    output logic                   dram_casl_n,
    output logic                   dram_cash_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [DATA_W-1:0]      dram_dq_o,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_i
);
    localparam int HC_W = $clog2(T_RAS_MAX + T_RP + 2);

    logic             ref_pend, ref_ack;
    logic             col_nx, ref_nx, wr_nx;
    logic [LANES-1:0] be_nx, cas_n;

    edo_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_i    (ref_ack),
        .pending_o(ref_pend)
    );

    edo_seq #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
        .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_CSR(T_CSR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .ref_pend_i(ref_pend),
        .ref_ack_o (ref_ack),
        .dq_i      (dram_dq_i),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ras_n     (dram_ras_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .addr      (dram_addr),
        .dq_o      (dram_dq_o),
        .dq_oe     (dram_dq_oe),
        .col_nx_o  (col_nx),
        .ref_nx_o  (ref_nx),
        .wr_nx_o   (wr_nx),
        .be_nx_o   (be_nx)
    );

    edo_lane_strobes #(.LANES(LANES)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_nx_i(col_nx),
        .ref_nx_i(ref_nx),
        .wr_nx_i (wr_nx),
        .be_nx_i (be_nx),
        .cas_n_o (cas_n)
    );

    assign dram_casl_n = cas_n[0];
    assign dram_cash_n = cas_n[LANES-1];

    // Pin-level RAS low/high time counters for the timing checks below
    logic [HC_W-1:0] lo_cnt_q, hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
            hi_cnt_q <= '0;
        end else begin
            lo_cnt_q <= dram_ras_n ? '0 : lo_cnt_q + 1'b1;
            if (!dram_ras_n)                  hi_cnt_q <= '0;
            else if (int'(hi_cnt_q) < T_RP)   hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    a_r8_ras_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (int'(lo_cnt_q) >= T_RAS_MIN));
    a_r8_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (int'(hi_cnt_q) >= T_RP));
    a_r11_ras_max_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (int'(lo_cnt_q) < T_RAS_MAX));
    a_r5_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);
    a_r5_turn_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_dq_oe) |-> $past(dram_oe_n));
    a_r5_turn_off_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_oe_n) |-> !$past(dram_dq_oe));
    a_r9_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_casl_n) |-> (!dram_cash_n && dram_we_n));
endmodule

// File: tb/edo_dram_ctrl_tb.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb;
    localparam int T_RCD = 2, T_CAS = 3, T_CP = 1, T_RP = 4;
    localparam int T_RAS_MIN = 6, T_RAS_MAX = 60, REF_I = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic        ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
    logic [9:0]  dram_addr;
    logic [15:0] dq_o;
    logic [15:0] dq_i = 16'h0BAD;

    always #4 clk = ~clk;

    edo_dram_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
        .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_CSR(1),
        .REF_INTERVAL(REF_I)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(ras_n), .dram_casl_n(casl_n), .dram_cash_n(cash_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
        .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i)
    );

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural DRAM model ----------------
    logic [15:0] mem [int];
    logic [9:0]  m_row = '0, m_col = '0;
    logic        p_ras = 1'b1, p_l = 1'b1, p_h = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
    int ras_lo = 0, ras_hi = 100, l_hi = 100, h_hi = 100;
    int opens = 0, refs = 0, viol_t = 0, viol_b = 0, viol_c = 0;

    function automatic logic [15:0] rd_mem(input logic [9:0] r, input logic [9:0] c);
        int k = int'({r, c});
        if (mem.exists(k)) return mem[k];
        return 16'h0BAD;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                if (casl_n && cash_n) begin
                    m_row = dram_addr; opens++;
                    if (ras_hi < T_RP) viol_t++;
                    l_hi = 100; h_hi = 100;
                end else if (!casl_n && !cash_n) begin
                    refs++;
                    if (!we_n) viol_c++;
                end else viol_c++;
            end
            if (!p_ras && ras_n && ras_lo < T_RAS_MIN) viol_t++;
            if (!ras_n && p_ras == 1'b0 && (casl_n == 1'b0 || cash_n == 1'b0) && (p_l && p_h)) begin
                m_col = dram_addr;
            end
            if (!ras_n && !p_ras) begin
                if (p_l && !casl_n) begin
                    m_col = dram_addr;
                    if (l_hi < T_CP) viol_t++;
                    if (!we_n) begin
                        if (!dq_oe) viol_b++;
                        mem[int'({m_row, m_col})] = {rd_mem(m_row, m_col)[15:8], dq_o[7:0]};
                    end
                end
                if (p_h && !cash_n) begin
                    m_col = dram_addr;
                    if (h_hi < T_CP) viol_t++;
                    if (!we_n) begin
                        if (!dq_oe) viol_b++;
                        mem[int'({m_row, m_col})] = {dq_o[15:8], rd_mem(m_row, m_col)[7:0]};
                    end
                end
            end
            if (dq_oe && !oe_n) viol_b++;
            if (dq_oe && !p_oe) viol_b++;
            if (!oe_n && p_dqoe) viol_b++;
            if (!ras_n && !oe_n && (!casl_n || !cash_n)) dq_i = rd_mem(m_row, m_col);
            else dq_i = 16'h0BAD;
            if (!ras_n) begin ras_lo++; ras_hi = 0; if (ras_lo > T_RAS_MAX) viol_t++; end
            else begin ras_hi++; ras_lo = 0; end
            l_hi = casl_n ? l_hi + 1 : 0;
            h_hi = cash_n ? h_hi + 1 : 0;
            p_ras = ras_n; p_l = casl_n; p_h = cash_n; p_oe = oe_n; p_dqoe = dq_oe;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [19:0] a, input logic [1:0] be,
                          input logic [15:0] wd, output logic [15:0] rd);
        rd = '0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (!wr) begin
            @(negedge clk);
            while (!rd_valid) @(negedge clk);
            rd = rd_data;
            @(negedge clk);
            check(rd_valid == 1'b0, "R4 rd_valid single pulse", rd_valid, 0);
        end
    endtask

    task automatic sync_refresh();
        int r0 = refs;
        while (refs == r0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    typedef struct packed {
        logic        wr;
        logic [19:0] a;
        logic [1:0]  be;
        logic [15:0] d;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 20'h00005, 2'b11, 16'h1234},
        '{1'b1, 20'h00006, 2'b11, 16'hABCD},
        '{1'b0, 20'h00005, 2'b11, 16'h1234},
        '{1'b1, 20'h00005, 2'b01, 16'h00EE},
        '{1'b0, 20'h00005, 2'b11, 16'h12EE},
        '{1'b1, 20'h00005, 2'b10, 16'h77FF},
        '{1'b0, 20'h00005, 2'b11, 16'h77EE},
        '{1'b1, 20'h00005, 2'b00, 16'h5555},
        '{1'b0, 20'h00005, 2'b11, 16'h77EE},
        '{1'b1, 20'h3FC05, 2'b11, 16'hBEEF},
        '{1'b0, 20'h00006, 2'b11, 16'hABCD},
        '{1'b0, 20'h3FC05, 2'b11, 16'hBEEF}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int o0, r0, c0, dc;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ras_n && casl_n && cash_n && we_n && oe_n && !dq_oe && !rd_valid && !req_ready,
              "R1 reset pins", {ras_n, casl_n, cash_n, we_n, oe_n, dq_oe, rd_valid, req_ready}, 8'b11111000);
        rst_n = 1'b1;
        @(negedge clk);
        check(ras_n && casl_n && cash_n && we_n && oe_n && !dq_oe && !rd_valid,
              "R1 first cycle after reset", {ras_n, casl_n, cash_n, we_n, oe_n, dq_oe, rd_valid}, 7'b1111100);

        // R3/R4: table of full-word and byte writes with read-back
        for (int i = 0; i < 12; i++) begin
            do_req(VECS[i].wr, VECS[i].a, VECS[i].be, VECS[i].d, rd);
            if (!VECS[i].wr) check(rd == VECS[i].d, "R3/R4 read-back", rd, VECS[i].d);
        end

        // R2: row and column on the shared address pins
        do_req(1'b1, {10'd700, 10'd33}, 2'b11, 16'hC0DE, rd);
        repeat (10) @(negedge clk);
        check(m_row == 10'd700, "R2 row address", m_row, 700);
        check(m_col == 10'd33, "R2 column address", m_col, 33);

        // R6: same-row requests share one activation
        sync_refresh();
        o0 = opens;
        do_req(1'b1, {10'd9, 10'd1}, 2'b11, 16'h1111, rd);
        do_req(1'b1, {10'd9, 10'd2}, 2'b11, 16'h2222, rd);
        do_req(1'b1, {10'd9, 10'd3}, 2'b11, 16'h3333, rd);
        do_req(1'b0, {10'd9, 10'd2}, 2'b11, 16'h0000, rd);
        check(rd == 16'h2222, "R6 page read", rd, 16'h2222);
        check(opens - o0 == 1, "R6 single activation", opens - o0, 1);

        // R7: row change forces precharge and a new activation
        sync_refresh();
        o0 = opens;
        do_req(1'b1, {10'd20, 10'd1}, 2'b11, 16'hAAAA, rd);
        do_req(1'b1, {10'd21, 10'd1}, 2'b11, 16'hBBBB, rd);
        do_req(1'b0, {10'd20, 10'd1}, 2'b11, 16'h0000, rd);
        check(rd == 16'hAAAA, "R7 read after row change", rd, 16'hAAAA);
        check(opens - o0 == 3, "R7 activations", opens - o0, 3);

        // R11: idle open page closes before the RAS limit
        sync_refresh();
        do_req(1'b1, {10'd5, 10'd7}, 2'b11, 16'h5A5A, rd);
        repeat (2 * T_RAS_MAX + 10) @(negedge clk);
        check(ras_n == 1'b1, "R11 idle page closed", ras_n, 1);

        // R9: refresh rate while idle
        r0 = refs;
        repeat (10 * REF_I) @(negedge clk);
        check((refs - r0 >= 9) && (refs - r0 <= 11), "R9 idle refresh count", refs - r0, 10);

        // R10: refresh kept under continuous page traffic
        r0 = refs; c0 = cyc;
        for (int i = 0; i < 150; i++) do_req(1'b1, {10'd30, 10'(i)}, 2'b11, 16'(i * 3), rd);
        dc = cyc - c0;
        check(refs - r0 >= dc / REF_I - 1, "R10 refresh under traffic", refs - r0, dc / REF_I);
        do_req(1'b0, {10'd30, 10'd100}, 2'b11, 16'h0000, rd);
        check(rd == 16'd300, "R10 data after refresh interleave", rd, 300);

        repeat (20) @(negedge clk);
        check(viol_t == 0, "R8 timing violations", viol_t, 0);
        check(viol_b == 0, "R5 bus violations", viol_b, 0);
        check(viol_c == 0, "R9 refresh order violations", viol_c, 0);
        check(refs > 0, "R9 refresh observed", refs, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule